// File: doc/BRIEF.md
# Host-fed speech byte request handshake

This block sits between a host processor and a speech decoder when the decoder is fed by the host rather than by a data memory. A pulse on a mode input opens a session. After a fixed settling delay the block signals busy, and after a longer delay it raises its first data request. The host answers each request with a write strobe qualified by an active-low chip select. The request is withdrawn on the clock edge after the strobe starts, and the byte is taken on the strobe's rising edge.

Each accepted byte goes into a one-byte holding register with a valid flag, and the decoder pops it from there. A new request goes out only when the holding register is empty, no accepted strobe is still open, and the decoder reports that it wants another byte. A strobe that arrives with no request pending does not touch the holding register. It sets a sticky overrun flag instead. The decoder ends the session with an end-of-message pulse, which returns the block to idle and releases busy.

All inputs are taken to be synchronous to `clk`. Delays are counted in clock cycles: a pulse width limit, a busy delay and a first-request delay. The first-request delay must be at least the busy delay. Reset is asserted asynchronously and released through a two-stage synchroniser.

Top module: `slv_dreq_hs`

## Requirements
- R1: While reset is held and after it is released with no stimulus, `dreq` is 0, `busy_n` is 1, `hold_vld` is 0 and `ovr` is 0.
- R2: A session opens on the first clock edge that samples `mode_in` low, if the preceding MD_MIN_CYC or more edges sampled it high. A shorter high pulse is ignored: `busy_n` stays 1 and `dreq` stays 0.
- R3: Count the session-opening edge as edge 0. `busy_n` goes low after edge BUSY_DLY. The first `dreq` rises after edge REQ_DLY, whatever `dec_need` is.
- R4: `mode_in` pulses while a session is open have no effect: `busy_n` stays 0 and pending requests stay pending.
- R5: A clock edge that samples `wr_n` low, after the previous edge sampled it high, while `cs_n` is low, clears `dreq` on that edge.
- R6: If that strobe began with a request pending, the edge that samples `wr_n` high again with `cs_n` low loads `wr_data` into `hold_data` and sets `hold_vld`. A strobe made with `cs_n` high is ignored and leaves `dreq`, `hold_vld` and `ovr` unchanged.
- R7: `hold_vld` and `hold_data` keep their values until a clock edge that samples `dec_take` high. That edge clears `hold_vld`.
- R8: Once the first request has been served, `dreq` is raised on the clock edge after the one where `hold_vld` is 0, no accepted strobe is open and `dec_need` is 1. It never rises while `hold_vld` is 1.
- R9: A strobe that begins (with `cs_n` low) while `dreq` is 0 leaves the holding register unchanged and sets `ovr`. `ovr` then stays 1 through the end of the session and is cleared only when the next session opens.
- R10: A clock edge that samples `dec_end` high during a session returns the block to idle. After that edge `busy_n` is 1, `dreq` is 0 and `hold_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_in | input | 1 | Session start pulse; a session opens when it falls |
| cs_n | input | 1 | Active-low chip select qualifying the write strobe |
| wr_n | input | 1 | Active-low write strobe from the host |
| wr_data | input | 8 | Byte from the host |
| dreq | output | 1 | Data request to the host |
| busy_n | output | 1 | Active-low busy |
| dec_need | input | 1 | Decoder wants another byte |
| dec_take | input | 1 | Decoder pops the holding register |
| dec_end | input | 1 | Decoder found the end-of-message code |
| hold_data | output | 8 | Holding register contents |
| hold_vld | output | 1 | Holding register is full |
| ovr | output | 1 | Sticky flag for a write made with no request pending |

## Verification
The hardest case to reach from the ports is a write strobe that begins with no request pending. For that to happen, the holding register must already be full or the decoder must be withholding demand. Otherwise the block re-raises `dreq` one cycle after a pop, and the stray strobe becomes a normal write. The bench first fills the holding register with a proper write and keeps `dec_take` low. It then strobes a second byte and checks that `ovr` rises while `hold_data` still holds the first byte. Later it ends the session and opens a new one, to show that the flag survives the end of the session and is cleared only when the next session opens.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  typedef enum logic [1:0] {
    SS_IDLE = 2'd0,
    SS_WAIT = 2'd1,
    SS_RUN  = 2'd2
  } sess_st_t;
endpackage

// File: rtl/sdr_rst_sync.sv
module sdr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      s1_q    <= 1'b1;
      rst_q_n <= s1_q;
    end
  end
endmodule

// File: rtl/sdr_mode_det.sv
module sdr_mode_det #(
  parameter int MD_MIN_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_in,
  input  logic idle,
  output logic start
);
  localparam int CW = $clog2(MD_MIN_CYC + 1);

  logic          mode_q, mode_nx;
  logic [CW-1:0] wid_cnt, wid_nx;
  logic          wid_ok;

  assign wid_ok = (wid_cnt >= CW'(MD_MIN_CYC));
  assign start  = mode_q & ~mode_in & wid_ok & idle;

  always_comb begin
    mode_nx = mode_in;
    if (!mode_in)    wid_nx = '0;
    else if (wid_ok) wid_nx = wid_cnt;
    else             wid_nx = wid_cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      wid_cnt <= '0;
    end else begin
      mode_q  <= mode_nx;
      wid_cnt <= wid_nx;
    end
  end
endmodule

// File: rtl/sdr_seq.sv
module sdr_seq
  import sdr_pkg::*;
#(
  parameter int BUSY_DLY = 3,
  parameter int REQ_DLY  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic dec_end,
  input  logic dec_need,
  input  logic hold_vld,
  input  logic armed,
  input  logic wr_fall,
  output logic dreq,
  output logic busy_n,
  output logic idle
);
  localparam int TW = $clog2(REQ_DLY + 1);

  sess_st_t      st_q, st_nx;
  logic [TW-1:0] tmr_q, tmr_nx;
  logic          tmr_en;
  logic          dreq_nx;

  assign idle   = (st_q == SS_IDLE);
  assign busy_n = ~(!idle && (tmr_q >= TW'(BUSY_DLY)));

  always_comb begin
    st_nx   = st_q;
    tmr_nx  = tmr_q;
    tmr_en  = 1'b0;
    dreq_nx = dreq;
    case (st_q)
      SS_IDLE: begin
        if (start) begin
          st_nx  = SS_WAIT;
          tmr_nx = '0;
          tmr_en = 1'b1;
        end
      end
      SS_WAIT: begin
        tmr_nx = tmr_q + TW'(1);
        tmr_en = 1'b1;
        if (tmr_q == TW'(REQ_DLY - 1)) begin
          st_nx   = SS_RUN;
          dreq_nx = 1'b1;
        end
      end
      SS_RUN: begin
        if (!dreq && !hold_vld && !armed && dec_need) dreq_nx = 1'b1;
      end
      default: st_nx = SS_IDLE;
    endcase
    if (wr_fall) dreq_nx = 1'b0;
    if (dec_end && !idle) begin
      st_nx   = SS_IDLE;
      dreq_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SS_IDLE;
      tmr_q <= '0;
      dreq  <= 1'b0;
    end else begin
      st_q <= st_nx;
      dreq <= dreq_nx;
      if (tmr_en) tmr_q <= tmr_nx;
    end
  end
endmodule

// File: rtl/sdr_wr_port.sv
module sdr_wr_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic [DW-1:0] wr_data,
  input  logic          dreq,
  input  logic          dec_take,
  input  logic          flush,
  input  logic          clr_ovr,
  output logic          wr_fall,
  output logic          armed,
  output logic [DW-1:0] hold_data,
  output logic          hold_vld,
  output logic          ovr
);
  logic wr_q;
  logic wr_rise, cap;
  logic armed_nx, vld_nx, ovr_nx, ld_en;

  assign wr_fall = wr_q & ~wr_n & ~cs_n;
  assign wr_rise = ~wr_q & wr_n;
  assign cap     = wr_rise & ~cs_n & armed;

  always_comb begin
    armed_nx = armed;
    if (flush)        armed_nx = 1'b0;
    else if (wr_fall) armed_nx = dreq;
    else if (wr_rise) armed_nx = 1'b0;

    vld_nx = hold_vld;
    ld_en  = 1'b0;
    if (flush) vld_nx = 1'b0;
    else if (cap) begin
      vld_nx = 1'b1;
      ld_en  = 1'b1;
    end else if (dec_take) vld_nx = 1'b0;

    ovr_nx = ovr;
    if (clr_ovr)              ovr_nx = 1'b0;
    else if (wr_fall && !dreq) ovr_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q      <= 1'b1;
      armed     <= 1'b0;
      hold_vld  <= 1'b0;
      hold_data <= '0;
      ovr       <= 1'b0;
    end else begin
      wr_q     <= wr_n;
      armed    <= armed_nx;
      hold_vld <= vld_nx;
      ovr      <= ovr_nx;
      if (ld_en) hold_data <= wr_data;
    end
  end
endmodule

// File: rtl/slv_dreq_hs.sv
module slv_dreq_hs #(
  parameter int DW         = 8,
  parameter int MD_MIN_CYC = 4,
  parameter int BUSY_DLY   = 3,
  parameter int REQ_DLY    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_in,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic [DW-1:0] wr_data,
  output logic          dreq,
  output logic          busy_n,
  input  logic          dec_need,
  input  logic          dec_take,
  input  logic          dec_end,
  output logic [DW-1:0] hold_data,
  output logic          hold_vld,
  output logic          ovr
);
  logic rst_q_n;
  logic sess_start, idle, wr_fall, armed, flush;

  assign flush = sess_start | (dec_end & ~idle);

  sdr_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  sdr_mode_det #(.MD_MIN_CYC(MD_MIN_CYC)) u_mode (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .mode_in (mode_in),
    .idle    (idle),
    .start   (sess_start)
  );

  sdr_seq #(.BUSY_DLY(BUSY_DLY), .REQ_DLY(REQ_DLY)) u_seq (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .start    (sess_start),
    .dec_end  (dec_end),
    .dec_need (dec_need),
    .hold_vld (hold_vld),
    .armed    (armed),
    .wr_fall  (wr_fall),
    .dreq     (dreq),
    .busy_n   (busy_n),
    .idle     (idle)
  );

  sdr_wr_port #(.DW(DW)) u_wr (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .cs_n      (cs_n),
    .wr_n      (wr_n),
    .wr_data   (wr_data),
    .dreq      (dreq),
    .dec_take  (dec_take),
    .flush     (flush),
    .clr_ovr   (sess_start),
    .wr_fall   (wr_fall),
    .armed     (armed),
    .hold_data (hold_data),
    .hold_vld  (hold_vld),
    .ovr       (ovr)
  );
endmodule

// File: rtl/sdr_chk.sv
module sdr_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          wr_n,
  input logic          dreq,
  input logic          busy_n,
  input logic          hold_vld,
  input logic [DW-1:0] hold_data,
  input logic          dec_take,
  input logic          dec_end,
  input logic          ovr,
  input logic          start
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !cs_n && !wr_n && $past(wr_n)) |=> !dreq); // R5

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_vld && !dec_take && !dec_end) |=> (hold_vld && $stable(hold_data))); // R7

  AST_REQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dreq) |-> !hold_vld); // R8

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !start) |=> ovr); // R9

  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_end |=> (busy_n && !dreq && !hold_vld)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy_n |-> !dreq); // R3
endmodule

bind slv_dreq_hs sdr_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .cs_n      (cs_n),
  .wr_n      (wr_n),
  .dreq      (dreq),
  .busy_n    (busy_n),
  .hold_vld  (hold_vld),
  .hold_data (hold_data),
  .dec_take  (dec_take),
  .dec_end   (dec_end),
  .ovr       (ovr),
  .start     (sess_start)
);

// File: tb/tb_slv_dreq_hs.sv
`timescale 1ns/1ps
module tb_slv_dreq_hs;
  localparam int MD_MIN = 4;
  localparam int BDLY   = 3;
  localparam int RDLY   = 10;
  localparam int NV     = 6;
  // each entry: {byte written, cycles dec_need stays low after the pop}
  localparam logic [15:0] VEC [NV] = '{
    16'hA5_00, 16'h00_02, 16'hFF_01, 16'h3C_04, 16'h81_00, 16'h5E_03
  };

  logic       clk = 1'b0;
  logic       rst_n, mode_in, cs_n, wr_n, dec_need, dec_take, dec_end;
  logic [7:0] wr_data;
  logic       dreq, busy_n, hold_vld, ovr;
  logic [7:0] hold_data;
  int         total = 0;
  int         bad   = 0;
  logic       mid_dreq;

  always #5 clk = ~clk;

  slv_dreq_hs dut (
    .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .cs_n(cs_n), .wr_n(wr_n),
    .wr_data(wr_data), .dreq(dreq), .busy_n(busy_n), .dec_need(dec_need),
    .dec_take(dec_take), .dec_end(dec_end), .hold_data(hold_data),
    .hold_vld(hold_vld), .ovr(ovr)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic mode_pulse(input int w);
    @(negedge clk);
    mode_in = 1'b1;
    repeat (w) @(negedge clk);
    mode_in = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] d, input logic cs);
    @(negedge clk);
    cs_n = cs; wr_n = 1'b0; wr_data = d;
    @(negedge clk);
    mid_dreq = dreq;
    wr_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic take;
    @(negedge clk);
    dec_take = 1'b1;
    @(negedge clk);
    dec_take = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_in = 1'b0; cs_n = 1'b1; wr_n = 1'b1; wr_data = '0;
    dec_need = 1'b0; dec_take = 1'b0; dec_end = 1'b0;
    repeat (3) @(negedge clk);
    chk(!dreq && busy_n && !hold_vld && !ovr, "R1 in reset", {dreq, busy_n, hold_vld, ovr}, 4'b0100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!dreq && busy_n && !hold_vld && !ovr, "R1 after reset", {dreq, busy_n, hold_vld, ovr}, 4'b0100);

    // R2: pulse shorter than the limit
    mode_pulse(MD_MIN - 1);
    repeat (RDLY + 4) @(negedge clk);
    chk(busy_n && !dreq, "R2 short pulse ignored", {busy_n, dreq}, 2'b10);

    // R2/R3: valid pulse, delays counted from edge 0
    mode_pulse(MD_MIN + 1);
    for (int k = 0; k <= RDLY; k++) begin
      @(negedge clk);
      chk(busy_n == (k < BDLY), "R3 busy timing", busy_n, (k < BDLY));
      chk(dreq == (k >= RDLY), "R3 first request timing", dreq, (k >= RDLY));
    end

    // table: R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      chk(dreq, "R8 request pending", dreq, 1);
      wr_byte(VEC[i][15:8], 1'b0);
      chk(!mid_dreq, "R5 request cleared by strobe", mid_dreq, 0);
      chk(hold_vld && hold_data == VEC[i][15:8], "R6 byte captured", hold_data, VEC[i][15:8]);
      take();
      chk(!hold_vld, "R7 pop empties", hold_vld, 0);
      for (int g = 0; g < int'(VEC[i][7:0]); g++) begin
        @(negedge clk);
        chk(!dreq, "R8 no request without demand", dreq, 0);
      end
      dec_need = 1'b1;
      @(negedge clk);
      chk(dreq, "R8 request on demand", dreq, 1);
      dec_need = 1'b0;
    end

    // R7/R8: demand while holding register full
    dec_need = 1'b1;
    wr_byte(8'h69, 1'b0);
    repeat (4) begin
      @(negedge clk);
      chk(!dreq && hold_vld && hold_data == 8'h69, "R8 full blocks request", {dreq, hold_vld}, 2'b01);
    end
    take();
    chk(!dreq, "R8 no request on pop edge", dreq, 0);
    @(negedge clk);
    chk(dreq, "R8 request after pop", dreq, 1);

    // R6: strobe with chip select high
    wr_byte(8'h5A, 1'b1);
    @(negedge clk);
    chk(dreq && !hold_vld && !ovr, "R6 deselected strobe ignored", {dreq, hold_vld, ovr}, 3'b100);

    // R9: stray write while full
    wr_byte(8'h3C, 1'b0);
    chk(hold_data == 8'h3C && !ovr, "R6 capture before stray", hold_data, 8'h3C);
    wr_byte(8'hEE, 1'b0);
    chk(ovr, "R9 overrun set", ovr, 1);
    chk(hold_vld && hold_data == 8'h3C, "R9 hold unchanged", hold_data, 8'h3C);
    take();
    @(negedge clk);
    chk(dreq, "R8 request after stray", dreq, 1);

    // R4: mode pulse during session
    mode_pulse(MD_MIN + 2);
    for (int k = 0; k < 2 * RDLY; k++) begin
      @(negedge clk);
      chk(!busy_n, "R4 busy held", busy_n, 0);
    end
    chk(dreq, "R4 request kept", dreq, 1);

    // R10: end of message with a byte held
    wr_byte(8'h77, 1'b0);
    @(negedge clk);
    dec_end = 1'b1;
    @(negedge clk);
    dec_end = 1'b0;
    chk(busy_n && !dreq && !hold_vld, "R10 back to idle", {busy_n, dreq, hold_vld}, 3'b100);
    chk(ovr, "R9 overrun sticky past end", ovr, 1);

    // R9: next session clears overrun
    dec_need = 1'b0;
    mode_pulse(MD_MIN);
    @(negedge clk);
    chk(!ovr && busy_n, "R9 overrun cleared by new session", {ovr, busy_n}, 2'b01);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule